// File: doc/BRIEF.md
# Restoring Integer Square Root Unit

This block computes the floor of the square root of an unsigned integer over several clock cycles. A radicand of `RAD_W` bits (16, 32 or 48) is presented with a one-cycle `start` pulse. A fixed number of cycles later, a one-cycle `done` pulse marks a `RAD_W/2`-bit root. The root stays on its output until the next result replaces it.

The upper half of a working copy of the radicand serves as the running remainder, and the lower half feeds it one bit per step as the copy shifts left. A mask with two adjacent set bits marks the current root bit and also counts the iterations: the loop ends when the lower of those two bits leaves the mask. Before each trial, the mask is XORed into the partial root, which appends a `01` pattern to it. When a bit shifted out of the remainder shows that the remainder is at least one full register wide, the next subtraction cannot borrow, so it is done without a test. The last root bit needs a trial one bit wider than the register. It is settled from the borrow, a zero test on the difference, and the next radicand bit.

Top module: `isqrt_restoring`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `done` is 0 and `root` is 0.
- R2: For every radicand x of `RAD_W` bits, the root delivered is floor(sqrt(x)), `RAD_W/2` bits wide, for `RAD_W` of 16, 32 and 48.
- R3: `done` is high for exactly one cycle, `RAD_W/2` rising edges after the edge that accepted `start`.
- R4: `root` changes only in the cycle in which `done` is high, and holds its value otherwise.
- R5: A `start` sampled while a computation is in progress, including its final cycle, is ignored: neither the result in flight nor its timing changes.
- R6: A radicand of 0 gives root 0, and the all-ones radicand gives the all-ones root.
- R7: For a perfect square k*k the root is k, for k*k+1 it is k, and for k*k-1 it is k-1 (k > 0).
- R8: A `start` sampled on the edge that follows the `done` cycle is accepted, so operations can run back to back every `RAD_W/2+1` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a computation when the unit is idle |
| radicand | input | RAD_W | Unsigned value, sampled with `start` |
| done | output | 1 | One-cycle pulse marking a valid `root` |
| root | output | RAD_W/2 | Floor square root of the last accepted radicand |

## Verification
Every result is due on the `RAD_W/2`-th rising edge after the edge that samples `start`. The bench reference model keeps a countdown of that length for the operation in flight and ignores any `start` while the countdown runs. On every falling edge it compares both `done` and `root` with the model, so a result that is early, late, repeated or wrong is caught in the cycle it goes wrong. Three instances of 16, 32 and 48 bits run side by side. The 16-bit instance covers both ends of its input range contiguously; the wider ones get perfect squares with their neighbours and random values of random magnitude.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRIAL = 2'd1,
    PH_LAST  = 2'd2
  } phase_e;
endpackage

// File: rtl/isqrt_step.sv
// One restoring iteration: trial subtract, set bit, shift, append 01.
module isqrt_step #(
  parameter int ROOT_W = 16
) (
  input  logic [ROOT_W-1:0] rem_hi,
  input  logic [ROOT_W-1:0] rem_lo,
  input  logic [ROOT_W-1:0] trial,
  input  logic [ROOT_W-1:0] mask,
  input  logic              force_set,
  output logic [ROOT_W-1:0] nxt_hi,
  output logic [ROOT_W-1:0] nxt_lo,
  output logic [ROOT_W-1:0] nxt_trial,
  output logic [ROOT_W-1:0] nxt_mask,
  output logic              carry_top,
  output logic              last_step
);
  logic [ROOT_W:0]   diff;
  logic              accept;
  logic [ROOT_W-1:0] kept;
  logic [ROOT_W-1:0] with_bit;

  always_comb begin
    diff      = {1'b0, rem_hi} - {1'b0, trial};
    // A set carry from the previous shift guarantees no borrow.
    accept    = force_set | ~diff[ROOT_W];
    kept      = accept ? diff[ROOT_W-1:0] : rem_hi;
    with_bit  = accept ? (trial | mask) : trial;
    {carry_top, nxt_hi, nxt_lo} = {kept, rem_lo, 1'b0};
    nxt_mask  = mask >> 1;
    // Move the 01 tail one place down for the next trial.
    nxt_trial = with_bit ^ nxt_mask;
    last_step = mask[0];
  end
endmodule

// File: rtl/isqrt_final.sv
// Resolves the least significant root bit, whose trial is one bit wider.
module isqrt_final #(
  parameter int ROOT_W = 16
) (
  input  logic [ROOT_W-1:0] rem_hi,
  input  logic              next_bit,
  input  logic [ROOT_W-1:0] trial,
  input  logic              top_carry,
  output logic [ROOT_W-1:0] root_out
);
  logic [ROOT_W:0] diff;
  logic            borrow;
  logic            is_zero;
  logic            bit0;

  always_comb begin
    diff     = {1'b0, rem_hi} - {1'b0, trial};
    borrow   = diff[ROOT_W];
    is_zero  = (diff[ROOT_W-1:0] == '0);
    bit0     = top_carry | (~borrow & (~is_zero | next_bit));
    root_out = {trial[ROOT_W-1:1], bit0};
  end
endmodule

// File: rtl/isqrt_restoring.sv
module isqrt_restoring
  import isqrt_pkg::*;
#(
  parameter  int RAD_W  = 32,
  localparam int ROOT_W = RAD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RAD_W-1:0]  radicand,
  output logic              done,
  output logic [ROOT_W-1:0] root
);
  localparam logic [ROOT_W-1:0] TRIAL_INIT = {2'b01, {(ROOT_W-2){1'b0}}};
  localparam logic [ROOT_W-1:0] MASK_INIT  = {2'b11, {(ROOT_W-2){1'b0}}};

  phase_e            state_q, state_d;
  logic [ROOT_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [ROOT_W-1:0] trial_q, trial_d, mask_q, mask_d;
  logic              force_q, force_d;
  logic [ROOT_W-1:0] root_q;
  logic              done_q;
  logic              load_en, step_en, dp_en, fin_en;

  logic [ROOT_W-1:0] s_hi, s_lo, s_trial, s_mask;
  logic              s_carry, s_last;
  logic [ROOT_W-1:0] f_root;

  isqrt_step #(.ROOT_W(ROOT_W)) u_step (
    .rem_hi   (hi_q),
    .rem_lo   (lo_q),
    .trial    (trial_q),
    .mask     (mask_q),
    .force_set(force_q),
    .nxt_hi   (s_hi),
    .nxt_lo   (s_lo),
    .nxt_trial(s_trial),
    .nxt_mask (s_mask),
    .carry_top(s_carry),
    .last_step(s_last)
  );

  isqrt_final #(.ROOT_W(ROOT_W)) u_final (
    .rem_hi   (hi_q),
    .next_bit (lo_q[ROOT_W-1]),
    .trial    (trial_q),
    .top_carry(force_q),
    .root_out (f_root)
  );

  // Phase sequencing
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:  if (start)  state_d = PH_TRIAL;
      PH_TRIAL: if (s_last) state_d = PH_LAST;
      PH_LAST:  state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  assign load_en = (state_q == PH_IDLE) && start;
  assign step_en = (state_q == PH_TRIAL);
  assign fin_en  = (state_q == PH_LAST);
  assign dp_en   = load_en | step_en;

  // Datapath next values
  always_comb begin
    if (load_en) begin
      hi_d    = radicand[RAD_W-1:ROOT_W];
      lo_d    = radicand[ROOT_W-1:0];
      trial_d = TRIAL_INIT;
      mask_d  = MASK_INIT;
      force_d = 1'b0;
    end else begin
      hi_d    = s_hi;
      lo_d    = s_lo;
      trial_d = s_trial;
      mask_d  = s_mask;
      force_d = s_carry;
    end
  end

  // Datapath registers: no reset, written only under enable
  always_ff @(posedge clk) begin
    if (dp_en) begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      trial_q <= trial_d;
      mask_q  <= mask_d;
      force_q <= force_d;
    end
  end

  // Control and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
      root_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_en;
      if (fin_en) root_q <= f_root;
    end
  end

  assign done = done_q;
  assign root = root_q;
endmodule

// File: rtl/isqrt_restoring_chk.sv
module isqrt_restoring_chk
  import isqrt_pkg::*;
#(
  parameter  int RAD_W  = 32,
  localparam int ROOT_W = RAD_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RAD_W-1:0]  radicand,
  input logic              done,
  input logic [ROOT_W-1:0] root,
  input phase_e            state,
  input logic [ROOT_W-1:0] mask
);
  logic [RAD_W-1:0] cap_q;
  logic [7:0]       lat_q;
  logic [RAD_W+1:0] sq_lo, sq_hi, cap_ext;
  logic [ROOT_W:0]  root_p1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      lat_q <= '0;
    end else if (state == PH_IDLE && start) begin
      cap_q <= radicand;
      lat_q <= '0;
    end else if (state != PH_IDLE) begin
      lat_q <= lat_q + 8'd1;
    end
  end

  always_comb begin
    root_p1 = {1'b0, root} + 1'b1;
    sq_lo   = {{(ROOT_W+2){1'b0}}, root} * {{(ROOT_W+2){1'b0}}, root};
    sq_hi   = {{(ROOT_W+1){1'b0}}, root_p1} * {{(ROOT_W+1){1'b0}}, root_p1};
    cap_ext = {2'b00, cap_q};
  end

  a_r2_root_is_floor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sq_lo <= cap_ext) && (sq_hi > cap_ext));

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == 8'(ROOT_W)));

  a_r3_mask_two_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_TRIAL) |-> ($countones(mask) == 2));

  a_r4_root_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(root));

  a_r5_no_start_in_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LAST && start) |=> (state == PH_IDLE));
endmodule

bind isqrt_restoring isqrt_restoring_chk #(.RAD_W(RAD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .radicand(radicand),
  .done    (done),
  .root    (root),
  .state   (state_q),
  .mask    (mask_q)
);

// File: tb/isqrt_restoring_tb.sv
module isqrt_lane #(
  parameter  int RAD_W = 32,
  parameter  int SEED  = 1,
  localparam int ROOT_W = RAD_W / 2
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic fin
);
  logic              start;
  logic [RAD_W-1:0]  radicand;
  logic              done;
  logic [ROOT_W-1:0] root;
  string             tag;

  isqrt_restoring #(.RAD_W(RAD_W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .radicand(radicand),
    .done    (done),
    .root    (root)
  );

  function automatic logic [ROOT_W-1:0] ref_root(input logic [63:0] x);
    logic [63:0] r, t;
    r = 64'd0;
    for (int b = ROOT_W - 1; b >= 0; b--) begin
      t = r | (64'd1 << b);
      if (t * t <= x) r = t;
    end
    return r[ROOT_W-1:0];
  endfunction

  // Behavioural reference: countdown per accepted operation
  logic              exp_done;
  logic [ROOT_W-1:0] exp_root, pend;
  bit                m_busy;
  int                m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_done = 1'b0;
      exp_root = '0;
      m_busy   = 1'b0;
      m_cnt    = 0;
    end else begin
      exp_done = 1'b0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy   = 1'b0;
          exp_done = 1'b1;
          exp_root = pend;
        end
      end else if (start) begin
        m_busy = 1'b1;
        m_cnt  = ROOT_W;
        pend   = ref_root({{(64-RAD_W){1'b0}}, radicand});
      end
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
  end

  always @(negedge clk) begin
    n_chk++;
    if (done !== exp_done) begin
      n_bad++;
      $display("FAIL %s lane %0d: done got %b exp %b", rst_n ? "R3" : "R1",
               RAD_W, done, exp_done);
    end
    n_chk++;
    if (root !== exp_root) begin
      n_bad++;
      $display("FAIL %s lane %0d: root got %h exp %h",
               !rst_n ? "R1" : (exp_done ? tag : "R4"), RAD_W, root, exp_root);
    end
  end

  // Caller sits just after a falling edge; returns just after the done cycle begins.
  task automatic issue(input logic [RAD_W-1:0] x);
    int guard;
    start    = 1'b1;
    radicand = x;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 4 * RAD_W) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [RAD_W-1:0] rnd_val();
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    return RAD_W'(v) >> ($urandom() % RAD_W);
  endfunction

  initial begin
    logic [63:0] k;
    logic [RAD_W-1:0] a, b;
    void'($urandom(SEED));
    fin      = 1'b0;
    start    = 1'b0;
    radicand = '0;
    tag      = "R1";
    @(posedge rst_n);
    @(negedge clk);
    // R6: extremes
    tag = "R6";
    issue('0);
    issue('1);
    issue(RAD_W'(1));
    issue(RAD_W'(2));
    issue(RAD_W'(3));
    // R5: start pulses during a computation, mid-way and in its last cycle
    tag = "R5";
    a = rnd_val();
    b = rnd_val();
    start = 1'b1; radicand = a;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; radicand = b;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    a = rnd_val();
    start = 1'b1; radicand = a;
    @(negedge clk);
    start = 1'b0;
    repeat (ROOT_W - 1) @(negedge clk);
    start = 1'b1; radicand = ~a;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (RAD_W == 16) begin
      // R2: contiguous low and high ranges, issued back to back (R8)
      tag = "R8";
      for (int v = 0; v < 4096; v++) issue(RAD_W'(v));
      tag = "R2";
      for (int v = 61440; v < 65536; v++) issue(RAD_W'(v));
    end else begin
      // R7: perfect squares and their neighbours
      tag = "R7";
      for (int i = 0; i < 220; i++) begin
        k = (i == 0) ? ((64'd1 << ROOT_W) - 64'd1) : 64'(RAD_W'(rnd_val()) >> ROOT_W);
        if (k == 0) k = 64'd1;
        issue(RAD_W'(k * k));
        issue(RAD_W'(k * k - 64'd1));
        issue(RAD_W'(k * k + 64'd1));
      end
      // R2: random values of random magnitude
      tag = "R2";
      for (int i = 0; i < 500; i++) issue(rnd_val());
    end
    repeat (3) @(negedge clk);
    fin = 1'b1;
  end
endmodule

module isqrt_restoring_tb;
  logic clk;
  logic rst_n;
  int   c16, c32, c48, b16, b32, b48;
  logic f16, f32, f48;
  int   wd_bad;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  isqrt_lane #(.RAD_W(16), .SEED(11)) u_lane16 (
    .clk(clk), .rst_n(rst_n), .n_chk(c16), .n_bad(b16), .fin(f16));
  isqrt_lane #(.RAD_W(32), .SEED(23)) u_lane32 (
    .clk(clk), .rst_n(rst_n), .n_chk(c32), .n_bad(b32), .fin(f32));
  isqrt_lane #(.RAD_W(48), .SEED(37)) u_lane48 (
    .clk(clk), .rst_n(rst_n), .n_chk(c48), .n_bad(b48), .fin(f48));

  initial begin
    int cyc;
    wd_bad = 0;
    rst_n  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(f16 && f32 && f48) && cyc < 190000) begin
      @(negedge clk);
      cyc++;
    end
    if (!(f16 && f32 && f48)) begin
      wd_bad = 1;
      $display("FAIL R3 watchdog: lanes finished %0d exp 3",
               int'(f16) + int'(f32) + int'(f48));
    end
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             c16 + c32 + c48 + wd_bad, b16 + b32 + b48 + wd_bad);
    $finish;
  end
endmodule